// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides conditional branches while they sit in the decode stage of a five-stage in-order pipeline. The pipeline assumes that every branch falls through and keeps fetching the instructions after it. The resolver works out whether that guess was right, and if it was wrong it steers fetch to the branch target.

It reads four values: the incremented fetch address, the instruction word held in the fetch/decode register, and two operand values that may already have been forwarded. It adds the scaled, sign-extended offset to the incremented address to form the target. It tests the two operands for equality with a bitwise XOR, an OR over all the XOR results and an inversion, so no ALU is involved.

When the branch is taken, the block raises the PC select and the fetch/decode flush strobe in the same cycle. At the next edge the surrounding pipeline loads the target into the PC and all zeros into the fetch/decode register. Since the all-zero word is a nop, a taken branch costs exactly one wasted cycle. The block is purely combinational between its data inputs and its outputs. None of its pins carries streamed data, so it has no valid/ready handshake and every pin is a plain control or data signal. The clock and reset drive only the embedded checks.

Top module: `id_branch_resolver`

## Requirements
- R1: `target_o` equals `pc_plus4_i` plus the sign-extended value of `ifid_instr_i[15:0]` multiplied by four, with the sum taken modulo 2^32. The value is present whatever the opcode is.
- R2: A branch is recognised only when `ifid_instr_i[31:26]` is 6'b000100. For any other opcode, including the all-zero nop, `pc_sel_o` and `ifid_flush_o` are both 0.
- R3: A recognised branch is taken only when `rs_val_i` and `rt_val_i` agree in all 32 bits. Operands that differ in a single bit, whether bit 31 or bit 0, give not taken.
- R4: For a taken branch, `pc_sel_o` is 1 (select the target) and `ifid_flush_o` is 1. Both appear in the same cycle as the inputs that cause them.
- R5: For a recognised branch with unequal operands, `pc_sel_o` is 0 (select the sequential address) and `ifid_flush_o` is 0.
- R6: While `stall_i` is 1, `pc_sel_o` and `ifid_flush_o` are both 0, even when the operands are equal. The decision is made once `stall_i` returns to 0.
- R7: A negative offset (bit 15 of the instruction set) gives a target lower than `pc_plus4_i`. The offset 16'hFFFF gives `pc_plus4_i - 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset; disables the checks |
| pc_plus4_i | input | 32 | Incremented fetch address held in the fetch/decode register |
| ifid_instr_i | input | 32 | Instruction word held in the fetch/decode register |
| rs_val_i | input | 32 | First compare operand, already forwarded |
| rt_val_i | input | 32 | Second compare operand, already forwarded |
| stall_i | input | 1 | Load-use stall request for the current cycle |
| pc_sel_o | output | 1 | 1 selects the branch target as the next PC, 0 selects PC+4 |
| target_o | output | 32 | Branch target address |
| ifid_flush_o | output | 1 | Zeroes the fetch/decode register at the next edge |

## Verification
The checks assume that the two operand values are settled and already forwarded before the clock edge. They also assume that `stall_i` comes from the load-use detector of the same cycle. The bench changes inputs only just after a rising edge and reads the outputs at the falling edge, so every observed value comes from stable inputs. The stimulus covers both opcode classes, operands that differ in exactly one bit, stall together with equality, and offsets of both signs, including ones that make the target wrap.

// File: rtl/id_branch_pkg.sv
package id_branch_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;

  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_TARGET = 1'b1
  } npc_sel_e;
endpackage

// File: rtl/br_target_gen.sv
module br_target_gen
  import id_branch_pkg::*;
#(
  parameter int unsigned AW = XLEN,
  parameter int unsigned IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_plus4_i,
  input  logic [IW-1:0] imm_i,
  output logic [AW-1:0] target_o
);
  localparam int unsigned EXT_W = AW - IW - 2;

  logic [AW-1:0] offset;

  // sign-extend, then scale by four (word offset to byte offset)
  assign offset   = {{EXT_W{imm_i[IW-1]}}, imm_i, 2'b00};
  assign target_o = pc_plus4_i + offset;

  // R1: scaling never disturbs the two low address bits
  p_low_bits_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    target_o[1:0] == pc_plus4_i[1:0]);

  // R7: a negative offset always moves the target downward
  p_neg_goes_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_i[IW-1] && pc_plus4_i >= AW'(1 << (IW + 2))) |-> (target_o < pc_plus4_i));
endmodule

// File: rtl/br_eq_compare.sv
module br_eq_compare
  import id_branch_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] diff;

  // one XOR per bit pair; no subtractor and no carry chain
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = a_i[i] ^ b_i[i];
  end

  // OR every difference bit together, then invert
  assign eq_o = ~(|diff);

  // R3: equality is reported only for operands that match in every bit
  p_eq_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eq_o |-> (a_i == b_i));
  // R3: a difference in a single bit is never reported as equal
  p_one_bit_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a_i ^ b_i) == 1) |-> !eq_o);
endmodule

// File: rtl/br_decide.sv
module br_decide
  import id_branch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             eq_i,
  input  logic             stall_i,
  output npc_sel_e         npc_sel_o,
  output logic             flush_o
);
  logic is_branch;
  logic taken;

  assign is_branch = (opcode_i == OPC_BR_EQ);
  // stall holds the decision back so a stale comparison never acts
  assign taken     = is_branch & eq_i & ~stall_i;
  assign npc_sel_o = taken ? NPC_TARGET : NPC_SEQ;
  assign flush_o   = taken;

  // R2: instructions that are not branches leave fetch alone
  p_nonbranch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i != OPC_BR_EQ) |-> (!flush_o && npc_sel_o == NPC_SEQ));
  // R4: a flush is only ever the result of an equal comparison
  p_flush_needs_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> eq_i);
  // R5: unequal operands keep the sequential path
  p_unequal_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_i |-> (npc_sel_o == NPC_SEQ && !flush_o));
  // R6: no redirect while a stall is requested
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (!flush_o && npc_sel_o == NPC_SEQ));
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import id_branch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_plus4_i,
  input  logic [XLEN-1:0] ifid_instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic            stall_i,
  output logic            pc_sel_o,
  output logic [XLEN-1:0] target_o,
  output logic            ifid_flush_o
);
  logic     ops_equal;
  npc_sel_e npc_sel;

  br_target_gen #(.AW(XLEN), .IW(IMM_W)) u_tgt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_plus4_i (pc_plus4_i),
    .imm_i      (ifid_instr_i[IMM_W-1:0]),
    .target_o   (target_o)
  );

  br_eq_compare #(.W(XLEN)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (rs_val_i),
    .b_i   (rt_val_i),
    .eq_o  (ops_equal)
  );

  br_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode_i  (ifid_instr_i[XLEN-1:OPC_LSB]),
    .eq_i      (ops_equal),
    .stall_i   (stall_i),
    .npc_sel_o (npc_sel),
    .flush_o   (ifid_flush_o)
  );

  assign pc_sel_o = (npc_sel == NPC_TARGET);

  // R4: redirect and flush always travel together
  p_sel_flush_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o == ifid_flush_o);
endmodule

// File: tb/tb_id_branch_resolver.sv
module tb_id_branch_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc4 = '0, instr = '0, rs = '0, rt = '0;
  logic        stall = 1'b0;
  logic        sel, flush;
  logic [31:0] tgt;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk; // 50 MHz

  id_branch_resolver dut (
    .clk(clk), .rst_n(rst_n), .pc_plus4_i(pc4), .ifid_instr_i(instr),
    .rs_val_i(rs), .rt_val_i(rt), .stall_i(stall),
    .pc_sel_o(sel), .target_o(tgt), .ifid_flush_o(flush)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // behavioural reference, compared at the falling edge
  task automatic apply(logic [31:0] p, logic [31:0] ins, logic [31:0] a,
                       logic [31:0] b, logic st, string req);
    int off;
    logic take;
    logic [31:0] etgt;
    @(posedge clk); #1;
    pc4 = p; instr = ins; rs = a; rt = b; stall = st;
    off  = int'($signed(ins[15:0])) * 4;
    etgt = p + 32'(off);
    take = (ins[31:26] == 6'd4) && (a == b) && !st;
    @(negedge clk);
    check({req, " target R1"}, tgt, etgt);
    check({req, " sel"}, {31'b0, sel}, {31'b0, take});
    check({req, " flush"}, {31'b0, flush}, {31'b0, take});
  endtask

  localparam logic [31:0] BEQ = 32'h1000_0000; // opcode 6'b000100

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset nop sel", {31'b0, sel}, 32'd0);
    check("R2 reset nop flush", {31'b0, flush}, 32'd0);
    rst_n = 1'b1;
    apply(32'h0000_1004, BEQ | 32'h0008, 32'h55, 32'h55, 0, "R4 taken");
    apply(32'h0000_1004, BEQ | 32'h0008, 32'h55, 32'h56, 0, "R5 not taken");
    apply(32'h0000_2000, BEQ | 32'h0003, 32'h8000_0001, 32'h0000_0001, 0, "R3 msb differs");
    apply(32'h0000_2000, BEQ | 32'h0003, 32'h1234_5678, 32'h1234_5679, 0, "R3 lsb differs");
    apply(32'h0000_4000, BEQ | 32'hFFFF, 32'hA, 32'hA, 0, "R7 minus one");
    check("R7 value", tgt, 32'h0000_3FFC);
    apply(32'h0000_4000, BEQ | 32'h8000, 32'h0, 32'h0, 0, "R7 most negative");
    apply(32'h0000_0004, BEQ | 32'hFFFE, 32'h7, 32'h7, 0, "R1 wrap low");
    apply(32'hFFFF_FFF8, BEQ | 32'h0004, 32'h7, 32'h7, 0, "R1 wrap high");
    apply(32'h0000_3000, BEQ | 32'h0010, 32'h9, 32'h9, 1, "R6 stalled");
    apply(32'h0000_3000, BEQ | 32'h0010, 32'h9, 32'h9, 0, "R6 after stall");
    apply(32'h0000_3000, 32'h0000_0000, 32'h0, 32'h0, 0, "R2 nop");
    apply(32'h0000_3000, 32'h1400_0010, 32'h1, 32'h1, 0, "R2 other opcode");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, ins;
      a   = $urandom;
      b   = ($urandom_range(0, 1) != 0) ? a : $urandom;
      ins = ($urandom_range(0, 2) != 0) ? ((BEQ & 32'hFC00_0000) | ($urandom & 32'h03FF_FFFF)) : $urandom;
      apply($urandom & 32'hFFFF_FFFC, ins, a, b, ($urandom_range(0, 4) == 0), "R3 random");
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule